// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block moves a block of bytes between one peripheral and memory without the processor handling the data. Software loads a start address, a byte count and a control word through a small register port. When the peripheral asks for service, the engine requests the system bus from the processor with a hold request. Once the processor grants the bus, the engine acknowledges the peripheral and drives the memory address together with a read or write strobe. The data itself moves directly between the peripheral and memory on the shared data bus.

Two bus-tenure policies are selected by a control bit. In byte mode the engine gives the bus back after every byte and asks again while the peripheral still wants service. In burst mode it keeps the bus until the whole block is done. Completion sets a sticky done flag that drives the interrupt line. A status read clears the flag.

Register port: select 0 is the address, select 1 is the byte count, select 2 is the control word and select 3 is the read-only status. Control bits: bit 0 is direction (1 = peripheral to memory, memory write strobe; 0 = memory to peripheral, memory read strobe), bit 1 chooses burst (1) or byte (0) mode, and bit 2 is enable. Status bits: bit 0 is done and bit 1 is busy.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the hold request, peripheral acknowledge, both memory strobes and the interrupt are low, and all four register selects read zero.
- R2: A byte is moved only in a cycle where the hold request is high, the grant input is high and the peripheral request is high. In that cycle the peripheral acknowledge and exactly one strobe are high: the memory write strobe if control bit 0 is 1, the memory read strobe if it is 0. No acknowledge or strobe appears in any other cycle.
- R3: The hold request rises one cycle after the engine is idle with enable (control bit 2) set, a non-zero count and the peripheral request high. It stays high while waiting for the grant, and it does not rise without those three conditions.
- R4: In byte mode (control bit 1 = 0) each bus tenure carries one byte. The hold request falls in the cycle after the byte and stays low for at least one cycle before any new request, so an N-byte block takes N tenures.
- R5: In burst mode (control bit 1 = 1) the hold request stays high from the first byte to the last, even if the peripheral request pauses. It falls in the cycle after the last byte, so a block takes one tenure.
- R6: Every byte moved increments the address by one, wrapping modulo 2^ADDR_W, and decrements the count by one. Both values can be read back at selects 0 and 1.
- R7: On the last byte (count was 1) the done bit (status bit 0) and the interrupt output go high in the following cycle, and the enable bit clears.
- R8: A read strobe on select 3 clears done and the interrupt in the next cycle. If a clear and a completion fall in the same cycle, the completion wins.
- R9: While busy (status bit 1, any state other than idle), writes to the address, count and control registers are ignored.
- R10: With enable set and a count of zero, the peripheral request never raises the hold request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 2 | Register select |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (clears done on select 3) |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data for the current select |
| periph_req_i | input | 1 | Service request from the peripheral |
| periph_ack_o | output | 1 | Acknowledge to the peripheral, one per byte |
| hold_req_o | output | 1 | Bus request to the processor |
| hold_gnt_i | input | 1 | Bus grant from the processor |
| mem_addr_o | output | ADDR_W | Memory address of the current byte |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| irq_o | output | 1 | Completion interrupt |

## Verification
On every cycle the assertions check the following. Acknowledge and strobes appear only under a granted hold, with exactly one strobe. The address steps by one after each byte. Byte mode drops the hold after each byte. A released hold stays low for a cycle. The interrupt stays up until a status read. The bench scenarios show the properties that span a whole block: the number of tenures per block in each mode, the final address and count (including address wrap), ignored writes while busy, a zero count that never requests the bus, and completion winning over a simultaneous status clear.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HOLD = 2'd1,
    SQ_MOVE = 2'd2,
    SQ_GAP  = 2'd3
  } seq_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_STAT  = 2'd3;

  localparam int CTRL_DIR   = 0;
  localparam int CTRL_BURST = 1;
  localparam int CTRL_EN    = 2;
  localparam int CTRL_W     = 3;
endpackage

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              last,
  output logic              nonzero
);
  logic [ADDR_W-1:0] addr_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              addr_en;
  logic              cnt_en;

  always_comb begin
    addr_en  = ld_addr | step;
    cnt_en   = ld_cnt | step;
    addr_nxt = ld_addr ? addr_wdata : addr + ADDR_W'(1);
    cnt_nxt  = ld_cnt ? cnt_wdata : cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
    end else begin
      if (addr_en) addr <= addr_nxt;
      if (cnt_en)  cnt  <= cnt_nxt;
    end
  end

  assign last    = (cnt == CNT_W'(1));
  assign nonzero = (cnt != '0);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic burst,
  input  logic last,
  input  logic req,
  input  logic gnt,
  output logic hold_req,
  output logic beat,
  output logic busy
);
  seq_state_e state, state_nxt;

  assign hold_req = (state == SQ_HOLD) || (state == SQ_MOVE);
  assign beat     = (state == SQ_MOVE) && gnt && req;
  assign busy     = (state != SQ_IDLE);

  always_comb begin
    state_nxt = state;
    unique case (state)
      SQ_IDLE: if (armed && req) state_nxt = SQ_HOLD;
      SQ_HOLD: if (gnt) state_nxt = SQ_MOVE;
      SQ_MOVE: if (beat && (!burst || last)) state_nxt = SQ_GAP;
      SQ_GAP:  state_nxt = SQ_IDLE;
      default: state_nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [1:0]        sel,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              busy,
  input  logic              beat,
  input  logic              last,
  input  logic [REG_W-1:0]  addr_view,
  input  logic [REG_W-1:0]  cnt_view,
  output logic              ld_addr,
  output logic              ld_cnt,
  output logic              dir,
  output logic              burst,
  output logic              en,
  output logic              done,
  output logic [REG_W-1:0]  rdata
);
  logic wr_ok, ctrl_ld, finish, stat_rd;
  logic en_nxt, done_nxt;

  always_comb begin
    wr_ok    = we && !busy;
    ld_addr  = wr_ok && (sel == SEL_ADDR);
    ld_cnt   = wr_ok && (sel == SEL_COUNT);
    ctrl_ld  = wr_ok && (sel == SEL_CTRL);
    finish   = beat && last;
    stat_rd  = re && (sel == SEL_STAT);
    en_nxt   = finish ? 1'b0 : (ctrl_ld ? ctrl_wdata[CTRL_EN] : en);
    done_nxt = finish ? 1'b1 : (stat_rd ? 1'b0 : done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir   <= 1'b0;
      burst <= 1'b0;
      en    <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (ctrl_ld) begin
        dir   <= ctrl_wdata[CTRL_DIR];
        burst <= ctrl_wdata[CTRL_BURST];
      end
      en   <= en_nxt;
      done <= done_nxt;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ADDR:  rdata = addr_view;
      SEL_COUNT: rdata = cnt_view;
      SEL_CTRL:  rdata = REG_W'({en, burst, dir});
      default:   rdata = REG_W'({busy, done});
    endcase
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int CNT_W  = 16,
  localparam int REG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_sel,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              periph_req_i,
  output logic              periph_ack_o,
  output logic              hold_req_o,
  input  logic              hold_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              irq_o
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic              ld_addr, ld_cnt, step, last, nonzero;
  logic              ctrl_dir, ctrl_burst, ctrl_en, done, busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;

  dma_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ld_addr    (ld_addr),
    .ld_cnt     (ld_cnt),
    .addr_wdata (cfg_wdata[ADDR_W-1:0]),
    .cnt_wdata  (cfg_wdata[CNT_W-1:0]),
    .step       (step),
    .addr       (cur_addr),
    .cnt        (cur_cnt),
    .last       (last),
    .nonzero    (nonzero)
  );

  dma_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .armed    (ctrl_en && nonzero),
    .burst    (ctrl_burst),
    .last     (last),
    .req      (periph_req_i),
    .gnt      (hold_gnt_i),
    .hold_req (hold_req_o),
    .beat     (step),
    .busy     (busy)
  );

  dma_regs #(.REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we         (cfg_we),
    .re         (cfg_re),
    .sel        (cfg_sel),
    .ctrl_wdata (cfg_wdata[CTRL_W-1:0]),
    .busy       (busy),
    .beat       (step),
    .last       (last),
    .addr_view  (REG_W'(cur_addr)),
    .cnt_view   (REG_W'(cur_cnt)),
    .ld_addr    (ld_addr),
    .ld_cnt     (ld_cnt),
    .dir        (ctrl_dir),
    .burst      (ctrl_burst),
    .en         (ctrl_en),
    .done       (done),
    .rdata      (cfg_rdata)
  );

  assign periph_ack_o = step;
  assign mem_rd_o     = step && !ctrl_dir;
  assign mem_wr_o     = step && ctrl_dir;
  assign mem_addr_o   = cur_addr;
  assign irq_o        = done;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_sel,
  input logic              cfg_re,
  input logic              periph_ack_o,
  input logic              hold_req_o,
  input logic              hold_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              irq_o,
  input logic              burst
);
  AST_STROBE_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o || periph_ack_o) |-> (hold_gnt_i && hold_req_o)); // R2

  AST_ONE_STROBE_PER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ack_o || mem_rd_o || mem_wr_o) |-> (periph_ack_o && $countones({mem_rd_o, mem_wr_o}) == 1)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack_o |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R6

  AST_BYTE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ack_o && !burst) |=> !hold_req_o); // R4

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req_o) |=> !hold_req_o); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(cfg_re && cfg_sel == 2'd3)) |=> irq_o); // R7
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_sel      (cfg_sel),
  .cfg_re       (cfg_re),
  .periph_ack_o (periph_ack_o),
  .hold_req_o   (hold_req_o),
  .hold_gnt_i   (hold_gnt_i),
  .mem_addr_o   (mem_addr_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .irq_o        (irq_o),
  .burst        (ctrl_burst)
);

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_sel;
  logic        cfg_we, cfg_re;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        preq, pack, hold_req, hold_gnt;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, irq;

  always #10 clk = ~clk;

  dma_xfer_engine u_dma_xfer_engine (
    .clk (clk), .rst_n (rst_n),
    .cfg_sel (cfg_sel), .cfg_we (cfg_we), .cfg_re (cfg_re),
    .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
    .periph_req_i (preq), .periph_ack_o (pack),
    .hold_req_o (hold_req), .hold_gnt_i (hold_gnt),
    .mem_addr_o (mem_addr), .mem_rd_o (mem_rd), .mem_wr_o (mem_wr),
    .irq_o (irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int tenures  = 0;
  bit prev_hold = 1'b0;
  bit chk_on    = 1'b0;
  int gnt_delay = 0;
  int hold_age  = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // processor side: grant after gnt_delay cycles of hold request
  always @(posedge clk) begin
    #1;
    if (hold_req) begin
      if (hold_age >= gnt_delay) hold_gnt = 1'b1;
      hold_age++;
    end else begin
      hold_gnt = 1'b0;
      hold_age = 0;
    end
  end

  // behavioural reference model
  logic [15:0] m_addr, m_cnt;
  logic        m_en, m_dir, m_burst, m_done;
  int          m_st, m_nst;
  bit          m_bt, m_lst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_cnt = 0; m_en = 0; m_dir = 0; m_burst = 0; m_done = 0; m_st = 0;
    end else begin
      m_bt  = (m_st == 2) && hold_gnt && preq;
      m_lst = (m_cnt == 16'd1);
      m_nst = m_st;
      case (m_st)
        0: if (m_en && m_cnt != 0 && preq) m_nst = 1;
        1: if (hold_gnt) m_nst = 2;
        2: if (m_bt && (!m_burst || m_lst)) m_nst = 3;
        default: m_nst = 0;
      endcase
      if (cfg_we && m_st == 0) begin
        case (cfg_sel)
          2'd0: m_addr = cfg_wdata;
          2'd1: m_cnt  = cfg_wdata;
          2'd2: begin m_dir = cfg_wdata[0]; m_burst = cfg_wdata[1]; m_en = cfg_wdata[2]; end
          default: ;
        endcase
      end
      if (cfg_re && cfg_sel == 2'd3) m_done = 0;
      if (m_bt) begin
        m_addr = m_addr + 16'd1;
        m_cnt  = m_cnt - 16'd1;
        if (m_lst) begin m_done = 1; m_en = 0; end
      end
      m_st = m_nst;
    end
  end

  logic [15:0] exp_rd;
  bit          e_beat;
  always @(negedge clk) begin
    if (chk_on) begin
      e_beat = (m_st == 2) && hold_gnt && preq;
      check(hold_req == (m_st == 1 || m_st == 2), "R3 hold_req", 32'(hold_req), 32'(m_st == 1 || m_st == 2));
      check(pack == e_beat, "R2 ack", 32'(pack), 32'(e_beat));
      check(mem_wr == (e_beat && m_dir), "R2 mem_wr", 32'(mem_wr), 32'(e_beat && m_dir));
      check(mem_rd == (e_beat && !m_dir), "R2 mem_rd", 32'(mem_rd), 32'(e_beat && !m_dir));
      if (e_beat) check(mem_addr == m_addr, "R6 addr", 32'(mem_addr), 32'(m_addr));
      check(irq == m_done, "R7 irq", 32'(irq), 32'(m_done));
      case (cfg_sel)
        2'd0: exp_rd = m_addr;
        2'd1: exp_rd = m_cnt;
        2'd2: exp_rd = {13'd0, m_en, m_burst, m_dir};
        default: exp_rd = {14'd0, m_st != 0, m_done};
      endcase
      check(cfg_rdata == exp_rd, "R9 rdata", 32'(cfg_rdata), 32'(exp_rd));
      if (hold_req && !prev_hold) tenures++;
      prev_hold = hold_req;
    end
  end

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    cfg_sel = s; cfg_wdata = d; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [15:0] v);
    cfg_sel = s;
    @(negedge clk);
    #1 v = cfg_rdata;
  endtask

  task automatic clear_status;
    cfg_sel = 2'd3; cfg_re = 1'b1;
    tick();
    cfg_re = 1'b0;
  endtask

  task automatic wait_irq;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) return;
    end
    check(1'b0, "R7 irq timeout", 0, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  logic [15:0] v;
  bit          irq_seen;

  initial begin
    rst_n = 1'b0; cfg_sel = 0; cfg_we = 0; cfg_re = 0; cfg_wdata = 0;
    preq = 0; hold_gnt = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (6) tick();

    // R1 reset state
    check(!hold_req && !pack && !mem_rd && !mem_wr && !irq, "R1 outputs idle",
          32'({hold_req, pack, mem_rd, mem_wr, irq}), 0);
    for (int s = 0; s < 4; s++) begin
      peek(2'(s), v);
      check(v == 0, "R1 register reads zero", 32'(v), 0);
    end

    // byte mode, peripheral to memory, 3 bytes
    wr(2'd0, 16'h1000); wr(2'd1, 16'd3); wr(2'd2, 16'b101);
    tenures = 0;
    repeat (3) tick();
    check(tenures == 0, "R3 no hold without peripheral request", 32'(tenures), 0);
    preq = 1'b1;
    wait_irq();
    preq = 1'b0;
    repeat (3) tick();
    check(tenures == 3, "R4 one tenure per byte", 32'(tenures), 3);
    peek(2'd0, v); check(v == 16'h1003, "R6 final address", 32'(v), 32'h1003);
    peek(2'd1, v); check(v == 16'd0, "R6 final count", 32'(v), 0);
    peek(2'd2, v); check(v == 16'b001, "R7 enable cleared", 32'(v), 1);
    peek(2'd3, v); check(v == 16'd1, "R7 done set", 32'(v), 1);

    clear_status();
    @(negedge clk);
    check(irq == 1'b0, "R8 read clears interrupt", 32'(irq), 0);
    peek(2'd3, v); check(v == 16'd0, "R8 done cleared", 32'(v), 0);

    // burst mode, memory to peripheral, address wrap, paused request
    gnt_delay = 2;
    wr(2'd0, 16'hFFFE); wr(2'd1, 16'd4); wr(2'd2, 16'b110);
    tenures = 0;
    preq = 1'b1;
    repeat (5) tick();
    preq = 1'b0;
    repeat (2) tick();
    preq = 1'b1;
    wait_irq();
    preq = 1'b0;
    repeat (3) tick();
    check(tenures == 1, "R5 single tenure per burst", 32'(tenures), 1);
    peek(2'd0, v); check(v == 16'h0002, "R6 address wraps", 32'(v), 32'h0002);
    clear_status();

    // writes while busy are ignored
    gnt_delay = 6;
    wr(2'd0, 16'h0200); wr(2'd1, 16'd2); wr(2'd2, 16'b100);
    preq = 1'b1;
    repeat (3) tick();
    peek(2'd3, v); check(v == 16'd2, "R9 busy while holding", 32'(v), 2);
    wr(2'd0, 16'h5555); wr(2'd1, 16'd9);
    wait_irq();
    preq = 1'b0;
    repeat (3) tick();
    peek(2'd0, v); check(v == 16'h0202, "R9 address write ignored", 32'(v), 32'h0202);
    peek(2'd1, v); check(v == 16'd0, "R9 count write ignored", 32'(v), 0);
    clear_status();

    // zero count never requests the bus
    gnt_delay = 0;
    wr(2'd1, 16'd0); wr(2'd2, 16'b100);
    tenures = 0;
    preq = 1'b1;
    repeat (10) tick();
    check(tenures == 0, "R10 zero count no hold", 32'(tenures), 0);
    preq = 1'b0;
    wr(2'd2, 16'd0);

    // completion wins over a simultaneous status clear
    wr(2'd0, 16'h0300); wr(2'd1, 16'd1); wr(2'd2, 16'b101);
    cfg_sel = 2'd3; cfg_re = 1'b1;
    preq = 1'b1;
    irq_seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq) irq_seen = 1'b1;
    end
    preq = 1'b0;
    tick();
    cfg_re = 1'b0;
    @(negedge clk);
    check(irq_seen, "R8 completion wins over clear", 32'(irq_seen), 1);
    check(irq == 1'b0, "R8 cleared afterwards", 32'(irq), 0);
    peek(2'd0, v); check(v == 16'h0301, "R6 single byte address", 32'(v), 32'h0301);

    repeat (3) tick();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule